// File: doc/BRIEF.md
# Cold-Boot Power Sequencer

This block is a synchronous controller that runs on a free-running board oscillator and puts a processor's cold-boot power-up in the right order. It watches a 3.3 V supply-good input and waits until that input has held steady long enough for the system clock to be stable. It then raises a power-good output to the processor. Power-good only ever rises. It keeps the processor reset low for a programmed delay so that the processor PLL can lock. The companion bridge reset is held low from power-on until after the processor reset has been released, so the two resets always overlap.

On the clock edge where the processor reset is released, the block captures a 4-bit frequency-ID input and holds it for later configuration logic. All delays are parameters in microseconds, and the block converts them to clock cycles from the clock-frequency parameter. If the supply drops before power-good has risen, the sequence starts again from the beginning. If the supply drops after power-good has risen, a sticky fault flag is set and power-good stays high.

Top module: `boot_power_sequencer`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `cpu_pwrok`, `cpu_reset_n`, `bridge_reset_n`, `boot_done` and `supply_fault` are all 0, and `fid_latched` is 4'h0.
- R2: `cpu_pwrok` rises exactly SETTLE_CYC = CLK_KHZ*SETTLE_US/1000 clock edges after the first edge that samples `supply_ok` high, provided `supply_ok` stays high for that whole time. With the defaults this is 300 edges, and `cpu_pwrok` is still 0 one edge earlier.
- R3: If `supply_ok` is sampled low before `cpu_pwrok` has risen, the settle count is discarded. The next time the supply comes up, a full SETTLE_CYC count starts again.
- R4: `cpu_reset_n` rises exactly RST_CYC = CLK_KHZ*RST_DELAY_US/1000 edges after `cpu_pwrok` rises (175 with the defaults). A RST_DELAY_US below 1000 is rejected at elaboration.
- R5: Once `cpu_pwrok` is 1, it stays 1 until `rst_n` is asserted, even if `supply_ok` later falls.
- R6: If `supply_ok` is sampled low while `cpu_pwrok` is 1, `supply_fault` becomes 1 on that edge and stays 1. The reset sequence timing is unchanged.
- R7: `bridge_reset_n` is 0 from reset until exactly BRIDGE_TAIL_CYC edges (4 by default) after `cpu_reset_n` rises. It is never 1 while `cpu_reset_n` is 0.
- R8: `fid_latched` takes the value of `fid_in` sampled on the edge where `cpu_reset_n` rises. After that it does not change, whatever `fid_in` does.
- R9: `boot_done` is a single-cycle pulse that is high in the cycle where `bridge_reset_n` first becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running board oscillator |
| rst_n | input | 1 | Active-low reset of the sequencer itself |
| supply_ok | input | 1 | 3.3 V supply-good indication |
| fid_in | input | FID_W | Frequency ID driven by the processor |
| cpu_pwrok | output | 1 | Monotonic power-good to the processor |
| cpu_reset_n | output | 1 | Active-low processor reset |
| bridge_reset_n | output | 1 | Active-low companion bridge reset |
| fid_latched | output | FID_W | Frequency ID captured at processor reset release |
| boot_done | output | 1 | One-cycle pulse when the sequence completes |
| supply_fault | output | 1 | Sticky flag: supply dropped after power-good |

## Verification
Every output comes from a register that is loaded from the next-state value, so each output changes on the edge where its count expires and not one cycle later. The checks are placed on that basis:
- Power-good is due SETTLE_CYC edges after the first edge that sees the supply high.
- The processor reset release is due RST_CYC edges after that, and the frequency ID is captured on the same edge.
- The bridge release and the done pulse come BRIDGE_TAIL_CYC edges later.
- The fault flag is due on the edge that samples the supply low.

The bench drives inputs and samples outputs one time unit after each rising edge. It counts those edges from the stimulus and checks both the edge just before each expected change and the edge of the change itself, so an output that moves one cycle early or one cycle late is caught.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAIT_CLK,
    ST_PWRGOOD,
    ST_HOLD,
    ST_RELEASE,
    ST_RUN
  } seq_state_t;

  // Whole clock cycles in a span of microseconds at a clock given in kHz.
  function automatic int unsigned us_to_cycles(input int unsigned clk_khz,
                                               input int unsigned span_us);
    return (clk_khz * span_us) / 1000;
  endfunction

  // Width of a counter that must reach the value n.
  function automatic int unsigned bits_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  function automatic int unsigned max3(input int unsigned a, b, c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  // Free-running up counter that stops at its maximum value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (clear)          count <= '0;
    else if (count != TOP)   count <= count + 1'b1;
  end
endmodule

// File: rtl/fid_capture.sv
module fid_capture #(
  parameter int unsigned FID_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [FID_W-1:0] fid_in,
  output logic [FID_W-1:0] fid_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fid_q <= '0;
    else if (capture) fid_q <= fid_in;
  end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import boot_seq_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 300,
  parameter int unsigned RST_CYC    = 175,
  parameter int unsigned TAIL_CYC   = 4,
  parameter int unsigned W          = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         supply_ok,
  input  logic [W-1:0] count,
  output logic         timer_clear,
  output logic         capture_evt,
  output seq_state_t   state,
  output logic         pwrok_q,
  output logic         cpu_rst_n_q,
  output logic         bridge_rst_n_q,
  output logic         done_q,
  output logic         fault_q
);
  localparam logic [W-1:0] SETTLE_LAST = W'(SETTLE_CYC - 1);
  localparam logic [W-1:0] HOLD_LAST   = W'(RST_CYC - 2);
  localparam logic [W-1:0] TAIL_LAST   = W'(TAIL_CYC - 1);

  seq_state_t nxt;
  logic       nxt_pwr_on;

  always_comb begin
    nxt         = state;
    timer_clear = 1'b0;
    unique case (state)
      ST_OFF: begin
        timer_clear = 1'b1;
        if (supply_ok) nxt = ST_WAIT_CLK;
      end
      ST_WAIT_CLK: begin
        if (!supply_ok) begin
          nxt         = ST_OFF;
          timer_clear = 1'b1;
        end else if (count == SETTLE_LAST) begin
          nxt         = ST_PWRGOOD;
          timer_clear = 1'b1;
        end
      end
      ST_PWRGOOD: begin
        nxt         = ST_HOLD;
        timer_clear = 1'b1;
      end
      ST_HOLD: begin
        if (count == HOLD_LAST) begin
          nxt         = ST_RELEASE;
          timer_clear = 1'b1;
        end
      end
      ST_RELEASE: begin
        if (count == TAIL_LAST) begin
          nxt         = ST_RUN;
          timer_clear = 1'b1;
        end
      end
      ST_RUN:  nxt = ST_RUN;
      default: nxt = ST_OFF;
    endcase
  end

  assign capture_evt = (state == ST_HOLD) && (nxt == ST_RELEASE);
  assign nxt_pwr_on  = (nxt == ST_PWRGOOD) || (nxt == ST_HOLD) ||
                       (nxt == ST_RELEASE) || (nxt == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= ST_OFF;
      pwrok_q        <= 1'b0;
      cpu_rst_n_q    <= 1'b0;
      bridge_rst_n_q <= 1'b0;
      done_q         <= 1'b0;
      fault_q        <= 1'b0;
    end else begin
      state          <= nxt;
      pwrok_q        <= pwrok_q | nxt_pwr_on;
      cpu_rst_n_q    <= (nxt == ST_RELEASE) || (nxt == ST_RUN);
      bridge_rst_n_q <= (nxt == ST_RUN);
      done_q         <= (nxt == ST_RUN) && (state != ST_RUN);
      fault_q        <= fault_q | (pwrok_q & ~supply_ok);
    end
  end
endmodule

// File: rtl/boot_power_sequencer.sv
module boot_power_sequencer
  import boot_seq_pkg::*;
#(
  parameter int unsigned CLK_KHZ         = 100,
  parameter int unsigned SETTLE_US       = 3000,
  parameter int unsigned RST_DELAY_US    = 1750,
  parameter int unsigned BRIDGE_TAIL_CYC = 4,
  parameter int unsigned FID_W           = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok,
  input  logic [FID_W-1:0] fid_in,
  output logic             cpu_pwrok,
  output logic             cpu_reset_n,
  output logic             bridge_reset_n,
  output logic [FID_W-1:0] fid_latched,
  output logic             boot_done,
  output logic             supply_fault
);
  localparam int unsigned SETTLE_CYC   = us_to_cycles(CLK_KHZ, SETTLE_US);
  localparam int unsigned RST_CYC      = us_to_cycles(CLK_KHZ, RST_DELAY_US);
  localparam int unsigned MIN_HOLD_CYC = us_to_cycles(CLK_KHZ, 1000);
  localparam int unsigned CNT_W        = bits_for(max3(SETTLE_CYC, RST_CYC, BRIDGE_TAIL_CYC));

  if (RST_DELAY_US < 1000) begin : g_bad_reset_delay
    $error("reset delay below 1.0 ms cannot cover PLL lock");
  end
  if (BRIDGE_TAIL_CYC < 1 || RST_CYC < 2 || SETTLE_CYC < 1) begin : g_bad_counts
    $error("sequencer delays must be at least one cycle");
  end

  // Internal events brought out by name for the checker.
  logic             timer_clear;
  logic             capture_evt;
  logic [CNT_W-1:0] phase_count;
  seq_state_t       seq_state;

  seq_timer #(.W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (timer_clear),
    .count (phase_count)
  );

  seq_fsm #(
    .SETTLE_CYC (SETTLE_CYC),
    .RST_CYC    (RST_CYC),
    .TAIL_CYC   (BRIDGE_TAIL_CYC),
    .W          (CNT_W)
  ) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .supply_ok      (supply_ok),
    .count          (phase_count),
    .timer_clear    (timer_clear),
    .capture_evt    (capture_evt),
    .state          (seq_state),
    .pwrok_q        (cpu_pwrok),
    .cpu_rst_n_q    (cpu_reset_n),
    .bridge_rst_n_q (bridge_reset_n),
    .done_q         (boot_done),
    .fault_q        (supply_fault)
  );

  fid_capture #(.FID_W(FID_W)) u_fid (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture_evt),
    .fid_in  (fid_in),
    .fid_q   (fid_latched)
  );
endmodule

// File: rtl/boot_seq_checker.sv
module boot_seq_checker #(
  parameter int unsigned SETTLE_CYC   = 300,
  parameter int unsigned MIN_HOLD_CYC = 100,
  parameter int unsigned FID_W        = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             supply_ok,
  input logic [FID_W-1:0] fid_in,
  input logic             cpu_pwrok,
  input logic             cpu_reset_n,
  input logic             bridge_reset_n,
  input logic [FID_W-1:0] fid_latched,
  input logic             boot_done,
  input logic             supply_fault,
  input logic             capture_evt
);
  int unsigned supply_run;
  int unsigned pwrok_run;

  // Count how long the supply has been up, and how long power-good has been high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      supply_run <= 0;
      pwrok_run  <= 0;
    end else begin
      supply_run <= !supply_ok ? 0 : (supply_run == 32'hFFFF_FFFF ? supply_run : supply_run + 1);
      pwrok_run  <= !cpu_pwrok ? 0 : (pwrok_run  == 32'hFFFF_FFFF ? pwrok_run  : pwrok_run + 1);
    end
  end

  AST_PWROK_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_pwrok) |-> supply_run >= SETTLE_CYC);                               // R2
  AST_RESET_HOLD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_reset_n) |-> pwrok_run >= MIN_HOLD_CYC);                            // R4
  AST_RESET_NEEDS_PWROK: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_pwrok |-> !cpu_reset_n);                                                 // R4
  AST_PWROK_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_pwrok |=> cpu_pwrok);                                                     // R5
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    supply_fault |=> supply_fault);                                               // R6
  AST_FAULT_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_pwrok && !supply_ok) |=> supply_fault);                                  // R6
  AST_BRIDGE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_reset_n |-> !bridge_reset_n);                                            // R7
  AST_FID_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> (fid_latched == $past(fid_in)) && $rose(cpu_reset_n));        // R8
  AST_FID_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_evt |=> $stable(fid_latched));                                       // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> !boot_done);                                                    // R9
  AST_DONE_WITH_BRIDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bridge_reset_n) |-> boot_done);                                         // R9
endmodule

bind boot_power_sequencer boot_seq_checker #(
  .SETTLE_CYC   (SETTLE_CYC),
  .MIN_HOLD_CYC (MIN_HOLD_CYC),
  .FID_W        (FID_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .supply_ok      (supply_ok),
  .fid_in         (fid_in),
  .cpu_pwrok      (cpu_pwrok),
  .cpu_reset_n    (cpu_reset_n),
  .bridge_reset_n (bridge_reset_n),
  .fid_latched    (fid_latched),
  .boot_done      (boot_done),
  .supply_fault   (supply_fault),
  .capture_evt    (capture_evt)
);

// File: tb/boot_power_sequencer_tb.sv
module boot_power_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  // 100 kHz clock: 100 cycles per millisecond.
  localparam int CYC_PER_MS = 100;
  localparam int SETTLE     = 3 * CYC_PER_MS;          // 3.0 ms
  localparam int HOLD       = (7 * CYC_PER_MS) / 4;    // 1.75 ms
  localparam int TAIL       = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       supply_ok = 1'b0;
  logic [3:0] fid_in = 4'h0;
  logic       cpu_pwrok, cpu_reset_n, bridge_reset_n, boot_done, supply_fault;
  logic [3:0] fid_latched;

  int vectors = 0;
  int errors  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  boot_power_sequencer u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .supply_ok      (supply_ok),
    .fid_in         (fid_in),
    .cpu_pwrok      (cpu_pwrok),
    .cpu_reset_n    (cpu_reset_n),
    .bridge_reset_n (bridge_reset_n),
    .fid_latched    (fid_latched),
    .boot_done      (boot_done),
    .supply_fault   (supply_fault)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n     = 1'b0;
    supply_ok = 1'b0;
    fid_in    = 4'h0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
  endtask

  // R1: every output at its power-on value.
  task automatic t_reset_state();
    do_reset();
    check("R1", "pwrok",  cpu_pwrok,      0);
    check("R1", "cpu_rst", cpu_reset_n,   0);
    check("R1", "bridge", bridge_reset_n, 0);
    check("R1", "done",   boot_done,      0);
    check("R1", "fault",  supply_fault,   0);
    check("R1", "fid",    fid_latched,    0);
  endtask

  // Full boot from supply rise; optional supply drop during the reset hold.
  task automatic run_boot(input logic [3:0] fid, input bit glitch);
    supply_ok = 1'b1;
    fid_in    = fid;
    repeat (SETTLE) tick();
    check("R2", "pwrok one edge early", cpu_pwrok, 0);
    tick();
    check("R2", "pwrok at settle", cpu_pwrok, 1);
    check("R4", "cpu reset held", cpu_reset_n, 0);
    for (int i = 1; i < HOLD; i++) begin
      tick();
      if (glitch && i == 50) begin
        check("R6", "no fault yet", supply_fault, 0);
        supply_ok = 1'b0;
      end
      if (glitch && i == 51) begin
        check("R6", "fault raised", supply_fault, 1);
        check("R5", "pwrok held through drop", cpu_pwrok, 1);
      end
    end
    check("R4", "cpu reset one edge early", cpu_reset_n, 0);
    check("R7", "bridge held", bridge_reset_n, 0);
    tick();
    check("R4", "cpu reset released", cpu_reset_n, 1);
    check("R8", "fid captured", fid_latched, fid);
    check("R7", "bridge still held", bridge_reset_n, 0);
    fid_in = ~fid;
    repeat (TAIL - 1) tick();
    check("R7", "bridge one edge early", bridge_reset_n, 0);
    check("R9", "done early", boot_done, 0);
    tick();
    check("R7", "bridge released", bridge_reset_n, 1);
    check("R9", "done pulse", boot_done, 1);
    tick();
    check("R9", "done cleared", boot_done, 0);
    check("R8", "fid held", fid_latched, fid);
    check("R5", "pwrok stays", cpu_pwrok, 1);
    if (glitch) check("R6", "fault sticky", supply_fault, 1);
    else        check("R6", "no fault", supply_fault, 0);
  endtask

  task automatic t_clean_boot();
    do_reset();
    run_boot(4'hA, 1'b0);
  endtask

  // R3: an early drop throws away the partial settle count.
  task automatic t_restart();
    do_reset();
    supply_ok = 1'b1;
    repeat (120) tick();
    supply_ok = 1'b0;
    repeat (2) tick();
    check("R3", "pwrok after early drop", cpu_pwrok, 0);
    run_boot(4'h3, 1'b0);
  endtask

  // R5, R6: drop after power-good.
  task automatic t_late_drop();
    do_reset();
    run_boot(4'hC, 1'b1);
    supply_ok = 1'b1;
    repeat (5) tick();
    check("R6", "fault stays after recovery", supply_fault, 1);
  endtask

  // R8: frequency ID ignores later input changes.
  task automatic t_fid_hold();
    do_reset();
    run_boot(4'h5, 1'b0);
    for (int k = 0; k < 4; k++) begin
      fid_in = 4'(k * 3 + 1);
      tick();
    end
    check("R8", "fid after wiggle", fid_latched, 4'h5);
    check("R9", "no second done", boot_done, 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    t_reset_state();
    t_clean_boot();
    t_restart();
    t_late_drop();
    t_fid_hold();
    finish_run();
  end
endmodule